// File: doc/BRIEF.md
# Byte-Addressed Halfword SRAM Bridge

This block lets a host that counts addresses in bytes use an external asynchronous SRAM whose every location is 16 bits wide. One SRAM word holds two host bytes, so the bridge puts the host address, minus its lowest bit, on the SRAM address pins. That lowest bit then picks which of the two active-low byte-lane enables is asserted. Single bytes can be read and written as well as full halfwords.

The host raises a request with an address, a size flag, a write flag and write data. The host holds the request until the bridge answers with a one-cycle ready pulse or a one-cycle error pulse. Each accepted access holds the SRAM chip enable low for a fixed number of clock cycles, set by a parameter. On a read, the data is captured in the last of those cycles. The bridge then releases the bus and leaves at least one idle cycle before the next access.

Top module: `sram16_bridge`

## Requirements
- R1: During an access the SRAM address equals the host byte address shifted right by one. Host address bit 0 never reaches the SRAM address pins.
- R2: The lane enables `sramLaneN[1:0]` are active low, with bit 0 for SRAM data bits 7:0 and bit 1 for bits 15:8. A byte access at an even address drives 2'b10. A byte access at an odd address drives 2'b01. A halfword access drives 2'b00. Between accesses both bits are high.
- R3: A halfword request (`hostHalf`=1) at an odd address produces a one-cycle `hostErr` pulse and no `hostReady`. Chip enable is not asserted and the SRAM contents are unchanged.
- R4: A byte read returns the selected byte on `hostRdata[7:0]` with bits 15:8 zero. A halfword read returns the whole SRAM word.
- R5: A byte write puts `hostWdata[7:0]` on both SRAM data lanes. Only the enabled lane is stored, so the other byte of the word keeps its value.
- R6: Every accepted access holds `sramCeN` low for exactly `STROBE_CYC` consecutive cycles (default 3). `hostReady` is high for one cycle, the first cycle after `sramCeN` returns high.
- R7: On writes the bridge drives the data bus only while `sramWeN` is low. On reads it leaves the bus at high impedance.
- R8: Between two accesses, even back-to-back ones, `sramCeN` stays high for at least one cycle after `hostReady`.
- R9: After reset, `sramCeN`, `sramOeN`, `sramWeN` and both lane enables are high, and `hostReady` and `hostErr` are low.
- R10: `sramOeN` and `sramWeN` are never low together, and neither is low while `sramCeN` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Request, held until ready or error |
| hostAddr | input | HOST_AW | Byte address |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostHalf | input | 1 | 1 = halfword, 0 = byte |
| hostWdata | input | 16 | Write data (byte writes use bits 7:0) |
| hostRdata | output | 16 | Read data, valid with hostReady |
| hostReady | output | 1 | One-cycle completion pulse |
| hostErr | output | 1 | One-cycle misaligned-request pulse |
| sramAddr | output | HOST_AW-1 | SRAM word address |
| sramDq | inout | 16 | SRAM data bus |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramLaneN | output | 2 | Byte-lane enables, active low |

## Verification
If the strobe counter is wrong, the chip-enable pulse has the wrong length at its very next rising edge. The ready pulse then arrives early or late in that same cycle. A wrong latched address bit or size flag shows during the strobe as the wrong word address or the wrong lane-enable pattern. It also shows later as a corrupted neighbour byte when that word is read back. If the read capture is mistimed or the byte is steered to the wrong lane, the value returned with the ready pulse of that access is wrong. A controller that skips the fault path asserts chip enable within one cycle of accepting a misaligned request.

// File: rtl/sram16_bridge_pkg.sv
package sram16_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_DONE,
    ST_FAULT,
    ST_GAP
  } bridgeState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch the host request
    logic strobe;   // SRAM access cycle
    logic capture;  // last strobe cycle: sample read data
    logic done;     // completion pulse
    logic fault;    // misaligned request pulse
  } bridgeCtl_t;

endpackage

// File: rtl/sram16_bridge_ctrl.sv
module sram16_bridge_ctrl
  import sram16_bridge_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       misaligned,
  output bridgeCtl_t ctl
);

  localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

  bridgeState_e state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (hostReq) state <= misaligned ? ST_FAULT : ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt == LAST) state <= ST_DONE;
          else             cnt   <= cnt + 1'b1;
        end
        ST_DONE:  state <= ST_GAP;
        ST_FAULT: state <= ST_GAP;
        ST_GAP:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = (state == ST_IDLE) && hostReq && !misaligned;
    ctl.strobe  = (state == ST_STROBE);
    ctl.capture = (state == ST_STROBE) && (cnt == LAST);
    ctl.done    = (state == ST_DONE);
    ctl.fault   = (state == ST_FAULT);
  end

endmodule

// File: rtl/sram16_bridge_dp.sv
module sram16_bridge_dp
  import sram16_bridge_pkg::*;
#(
  parameter int HOST_AW = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  bridgeCtl_t         ctl,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrite,
  input  logic               hostHalf,
  input  logic [15:0]        hostWdata,
  input  logic [15:0]        dqIn,
  output logic [15:0]        hostRdata,
  output logic [HOST_AW-2:0] sramAddr,
  output logic               sramCeN,
  output logic               sramOeN,
  output logic               sramWeN,
  output logic [1:0]         sramLaneN,
  output logic [15:0]        dqOut,
  output logic               dqOe
);

  localparam int SRAM_AW = HOST_AW - 1;

  logic [HOST_AW-1:0] addrQ;
  logic               writeQ;
  logic               halfQ;
  logic [15:0]        wdataQ;
  logic [15:0]        rdataQ;
  logic               oddByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      halfQ  <= 1'b0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= hostAddr;
        writeQ <= hostWrite;
        halfQ  <= hostHalf;
        wdataQ <= hostWdata;
      end
      if (ctl.capture && !writeQ) begin
        if (halfQ)        rdataQ <= dqIn;
        else if (oddByte) rdataQ <= {8'h00, dqIn[15:8]};
        else              rdataQ <= {8'h00, dqIn[7:0]};
      end
    end
  end

  assign oddByte  = addrQ[0];
  assign sramAddr = addrQ[HOST_AW-1:1];
  assign hostRdata = rdataQ;

  always_comb begin
    sramCeN   = !ctl.strobe;
    sramOeN   = !(ctl.strobe && !writeQ);
    sramWeN   = !(ctl.strobe && writeQ);
    dqOe      = ctl.strobe && writeQ;
    dqOut     = halfQ ? wdataQ : {wdataQ[7:0], wdataQ[7:0]};
    if (!ctl.strobe)  sramLaneN = 2'b11;
    else if (halfQ)   sramLaneN = 2'b00;
    else if (oddByte) sramLaneN = 2'b01;
    else              sramLaneN = 2'b10;
  end

  if (SRAM_AW < 1) begin : g_badAw
    initial $error("HOST_AW must be at least 2");
  end

endmodule

// File: rtl/sram16_bridge.sv
module sram16_bridge
  import sram16_bridge_pkg::*;
#(
  parameter int HOST_AW    = 20,
  parameter int STROBE_CYC = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrite,
  input  logic               hostHalf,
  input  logic [15:0]        hostWdata,
  output logic [15:0]        hostRdata,
  output logic               hostReady,
  output logic               hostErr,
  output logic [HOST_AW-2:0] sramAddr,
  inout  wire  [15:0]        sramDq,
  output logic               sramCeN,
  output logic               sramOeN,
  output logic               sramWeN,
  output logic [1:0]         sramLaneN
);

  bridgeCtl_t  ctl;
  logic        misaligned;
  logic [15:0] dqOut;
  logic        dqOe;

  assign misaligned = hostHalf && hostAddr[0];

  sram16_bridge_ctrl #(.STROBE_CYC(STROBE_CYC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .misaligned (misaligned),
    .ctl        (ctl)
  );

  sram16_bridge_dp #(.HOST_AW(HOST_AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .hostAddr  (hostAddr),
    .hostWrite (hostWrite),
    .hostHalf  (hostHalf),
    .hostWdata (hostWdata),
    .dqIn      (sramDq),
    .hostRdata (hostRdata),
    .sramAddr  (sramAddr),
    .sramCeN   (sramCeN),
    .sramOeN   (sramOeN),
    .sramWeN   (sramWeN),
    .sramLaneN (sramLaneN),
    .dqOut     (dqOut),
    .dqOe      (dqOe)
  );

  assign sramDq    = dqOe ? dqOut : 16'bz;
  assign hostReady = ctl.done;
  assign hostErr   = ctl.fault;

endmodule

// File: rtl/sram16_bridge_chk.sv
module sram16_bridge_chk #(
  parameter int STROBE_CYC = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostReady,
  input logic       hostErr,
  input logic       sramCeN,
  input logic       sramOeN,
  input logic       sramWeN,
  input logic [1:0] sramLaneN,
  input logic       dqOe
);

  int unsigned ceLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)        ceLowCnt <= 0;
    else if (!sramCeN) ceLowCnt <= ceLowCnt + 1;
    else               ceLowCnt <= 0;
  end

  // R6
  ce_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramCeN) |-> (ceLowCnt == STROBE_CYC));

  // R6
  ce_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramCeN |-> (ceLowCnt < STROBE_CYC));

  // R6
  ready_after_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramCeN) |-> hostReady);

  // R8
  gap_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> sramCeN);

  // R3
  fault_no_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> (sramCeN && !hostReady));

  // R3
  fault_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |=> (sramCeN && !hostErr));

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN));

  // R10
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramOeN || !sramWeN) |-> !sramCeN);

  // R7
  drive_only_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !sramWeN);

  // R2
  lanes_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramCeN |-> (sramLaneN == 2'b11));

  // R2
  lanes_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramCeN |-> (sramLaneN != 2'b11));

endmodule

bind sram16_bridge sram16_bridge_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostReady (hostReady),
  .hostErr   (hostErr),
  .sramCeN   (sramCeN),
  .sramOeN   (sramOeN),
  .sramWeN   (sramWeN),
  .sramLaneN (sramLaneN),
  .dqOe      (dqOe)
);

// File: tb/tb_sram16_bridge.sv
`timescale 1ns/1ps
module tb_sram16_bridge;

  localparam int AW    = 8;
  localparam int WORDS = 1 << (AW - 1);
  localparam int NCYC  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic          hostWrite = 1'b0;
  logic          hostHalf = 1'b0;
  logic [15:0]   hostWdata = '0;
  logic [15:0]   hostRdata;
  logic          hostReady, hostErr;
  logic [AW-2:0] sramAddr;
  wire  [15:0]   sramDq;
  logic          sramCeN, sramOeN, sramWeN;
  logic [1:0]    sramLaneN;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sram16_bridge #(.HOST_AW(AW), .STROBE_CYC(NCYC)) dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostAddr(hostAddr),
    .hostWrite(hostWrite), .hostHalf(hostHalf), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostReady(hostReady), .hostErr(hostErr),
    .sramAddr(sramAddr), .sramDq(sramDq), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramLaneN(sramLaneN)
  );

  // SRAM model
  logic [15:0] sram [WORDS];
  logic [15:0] shadow [WORDS];
  assign sramDq = (!sramCeN && !sramOeN && sramWeN) ? sram[sramAddr] : 16'bz;
  always @(posedge clk) begin
    if (!sramCeN && !sramWeN) begin
      if (!sramLaneN[0]) sram[sramAddr][7:0]  <= sramDq[7:0];
      if (!sramLaneN[1]) sram[sramAddr][15:8] <= sramDq[15:8];
    end
  end

  // Port monitor
  int ceRun = 0, gapRun = 100, lastCe = 0, lastGap = 0, strobes = 0;
  logic [AW-2:0] obsAddr;
  logic [1:0]    obsLane;
  logic [15:0]   obsDq;
  logic          obsWe, obsOe;
  always @(negedge clk) begin
    if (!sramCeN) begin
      if (ceRun == 0) begin lastGap = gapRun; strobes++; end
      ceRun++; gapRun = 0;
      obsAddr = sramAddr; obsLane = sramLaneN;
      obsWe = !sramWeN; obsOe = !sramOeN;
      if (!sramWeN) obsDq = sramDq;
    end else begin
      if (ceRun != 0) lastCe = ceRun;
      ceRun = 0; gapRun++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic wr, input logic hf,
                        input logic [15:0] wd, output logic [15:0] rd, output logic er);
    @(negedge clk);
    hostReq = 1'b1; hostAddr = a; hostWrite = wr; hostHalf = hf; hostWdata = wd;
    do @(negedge clk); while (!(hostReady || hostErr));
    rd = hostRdata; er = hostErr;
    hostReq = 1'b0;
    #1;
  endtask

  function automatic logic [1:0] expLane(input logic [AW-1:0] a, input logic hf);
    if (hf) return 2'b00;
    return a[0] ? 2'b01 : 2'b10;
  endfunction

  logic [15:0] rd, wd, expv;
  logic        er;
  logic [7:0]  b;
  int          sBefore;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(sramCeN && sramOeN && sramWeN, "R9", {sramCeN, sramOeN, sramWeN}, 3'b111);
    chk(sramLaneN == 2'b11, "R9", sramLaneN, 2'b11);
    chk(!hostReady && !hostErr, "R9", {hostReady, hostErr}, 2'b00);
    rstN = 1'b1;

    // Halfword writes to every word
    for (int w = 0; w < WORDS; w++) begin
      wd = 16'(w * 16'h0101) ^ 16'h5A3C;
      access(AW'(w * 2), 1'b1, 1'b1, wd, rd, er);
      shadow[w] = wd;
      chk(!er, "R3", er, 0);
      chk(obsAddr == (AW-1)'(w), "R1", obsAddr, w);
      chk(obsLane == 2'b00, "R2", obsLane, 2'b00);
      chk(lastCe == NCYC, "R6", lastCe, NCYC);
      chk(obsWe && !obsOe && obsDq == wd, "R7", obsDq, wd);
    end

    // Halfword reads of every word
    for (int w = 0; w < WORDS; w++) begin
      access(AW'(w * 2), 1'b0, 1'b1, 16'h0, rd, er);
      chk(rd == shadow[w], "R4", rd, shadow[w]);
      chk(!obsWe && obsOe, "R10", {obsWe, obsOe}, 2'b01);
      chk(lastCe == NCYC, "R6", lastCe, NCYC);
      chk(lastGap >= 1, "R8", lastGap, 1);
    end

    // Byte reads of every address
    for (int a = 0; a < 2 * WORDS; a++) begin
      access(AW'(a), 1'b0, 1'b0, 16'h0, rd, er);
      expv = {8'h00, a[0] ? shadow[a/2][15:8] : shadow[a/2][7:0]};
      chk(rd == expv, "R4", rd, expv);
      chk(obsAddr == (AW-1)'(a / 2), "R1", obsAddr, a / 2);
      chk(obsLane == expLane(AW'(a), 1'b0), "R2", obsLane, expLane(AW'(a), 1'b0));
    end

    // Byte writes to every address, upper host byte is noise
    for (int a = 0; a < 2 * WORDS; a++) begin
      b = 8'(a) ^ 8'h77;
      access(AW'(a), 1'b1, 1'b0, {~b, b}, rd, er);
      if (a[0]) shadow[a/2][15:8] = b; else shadow[a/2][7:0] = b;
      chk(obsDq == {b, b}, "R5", obsDq, {b, b});
      chk(obsLane == expLane(AW'(a), 1'b0), "R2", obsLane, expLane(AW'(a), 1'b0));
      // read back the whole word: neighbour byte untouched
      access(AW'(a & ~1), 1'b0, 1'b1, 16'h0, rd, er);
      chk(rd == shadow[a/2], "R5", rd, shadow[a/2]);
    end

    // Misaligned halfword requests
    for (int k = 0; k < 16; k++) begin
      sBefore = strobes;
      access(AW'(4 * k + 1), k[0], 1'b1, 16'hFFFF, rd, er);
      chk(er, "R3", er, 1);
      chk(strobes == sBefore, "R3", strobes, sBefore);
      access(AW'(4 * k), 1'b0, 1'b1, 16'h0, rd, er);
      chk(rd == shadow[2*k], "R3", rd, shadow[2*k]);
      chk(!er, "R3", er, 0);
    end

    // Back-to-back: idle between strobes
    access(AW'(2), 1'b1, 1'b1, 16'hBEEF, rd, er);
    shadow[1] = 16'hBEEF;
    access(AW'(3), 1'b0, 1'b0, 16'h0, rd, er);
    chk(lastGap >= 1, "R8", lastGap, 1);
    chk(rd == 16'h00BE, "R4", rd, 16'h00BE);
    @(negedge clk);
    chk(sramLaneN == 2'b11 && sramCeN, "R2", sramLaneN, 2'b11);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule